// File: doc/BRIEF.md
# Change-Detection Interrupt Controller

This block watches a set of 8-bit digital input ports and reports transitions on bits that software has chosen to watch. Each input bit can be armed separately for a low-to-high change, a high-to-low change, or both. Two global gates in a control byte switch rising and falling detection on or off for all ports together. A detected change latches a sticky edge flag. If a second qualifying change arrives before software has cleared that flag, an overflow flag is latched as well.

An interrupt request is raised from these flags when the master enable and the matching source enable are set. A service routine reads the status byte and confirms that the interrupt and edge bits are both set. It then writes both clear bits in one byte. The inputs are assumed to be already filtered, but they are asynchronous, so each bit passes through a two-flop synchroniser before edge detection. The register interface is byte-wide. Writes take effect on the write clock edge, and read data is registered.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After reset, every enable byte and the control byte read 0x00, the status byte reads 0x00 and `irq` is low.
- R2: The rising-enable byte of port p is written and read at offset 0x42+0x10*p, and the falling-enable byte at 0x43+0x10*p. Bit b of each byte arms input bit 8*p+b.
- R3: A low-to-high change on an input bit that is armed for rising, while control bit 3 (rising gate) is set, sets status bit 0 (edge flag) on the third clock edge after the change.
- R4: A high-to-low change on an input bit that is armed for falling, while control bit 4 (falling gate) is set, sets the edge flag with the same latency.
- R5: A change on a bit that is not armed for that direction, or whose global gate is clear, leaves the status byte unchanged.
- R6: A qualifying change that arrives while the edge flag is already set also sets status bit 1 (overflow).
- R7: Writing to offset 0x01 with bit 3 set clears the edge flag, and with bit 2 set clears the overflow flag. The other bits of that byte have no effect.
- R8: If a write that clears the edge flag lands in the same cycle as a new qualifying change, the edge flag stays set.
- R9: `irq` is a register, updated one edge after its inputs. It goes high when control bit 2 (master) is set and either the edge flag is set with control bit 0 set, or the overflow flag is set with control bit 1 set. Status bit 2 reads the current `irq` value.
- R10: Writing 0x00 to the control byte at offset 0x03 drops `irq` on the next edge and stops any further change from setting a flag.
- R11: The control byte reads back at offset 0x03 with the value written, in its low 5 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (8) | Register offset, used for both read and write |
| wdata | input | DW (8) | Write data byte |
| rdata | output | DW (8) | Registered read data for the offset presented on the previous edge |
| port_in | input | NPORTS*DW (32) | Asynchronous input lines, port p on bits 8p+7..8p |
| irq | output | 1 | Registered interrupt request |

## Verification
An input change driven between edges is captured by the first flop on the next edge, called E1. It reaches the edge-detect stage at E2 and sets the flag at E3. The request rises at E4. Because read data is registered, the status byte shows bit 0 after E4 and bit 2 after E5. The latency scenario holds the status offset on `addr` and samples on the falling edge after each of E3, E4 and E5, so a flag that arrives one edge early or late is caught. The race scenario times its clear write to land exactly on E3. Every other scenario waits several edges after a stimulus before reading, so that only the final state is judged.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

  // Register offsets (byte addresses)
  localparam logic [7:0] OFS_CLEAR  = 8'h01;
  localparam logic [7:0] OFS_STATUS = 8'h02;
  localparam logic [7:0] OFS_CTRL   = 8'h03;
  localparam logic [7:0] OFS_RISE0  = 8'h42;
  localparam logic [7:0] OFS_FALL0  = 8'h43;
  localparam int         OFS_STRIDE = 16;

  // Bit positions in the clear byte
  localparam int CLR_EDGE_BIT = 3;
  localparam int CLR_OVF_BIT  = 2;

  // Control byte, packed from bit 4 down to bit 0
  typedef struct packed {
    logic fall_gate;
    logic rise_gate;
    logic master;
    logic ovf_ie;
    logic edge_ie;
  } ctrl_t;

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] meta_q;
  logic [W-1:0] smp_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      smp_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      smp_q  <= meta_q;
      prev_q <= smp_q;
    end
  end

  assign rise = smp_q & ~prev_q;
  assign fall = ~smp_q & prev_q;

endmodule

// File: rtl/chg_regs.sv
module chg_regs
  import chg_irq_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int DW     = 8,
  parameter int AW     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [NPORTS*DW-1:0] rise_en,
  output logic [NPORTS*DW-1:0] fall_en,
  output ctrl_t                ctrl_q,
  output logic                 clr_edge,
  output logic                 clr_ovf
);

  localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_CLEAR = AW'(OFS_CLEAR);
  localparam int            CW      = $bits(ctrl_t);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [AW-1:0] A_RISE = AW'(int'(OFS_RISE0) + p * OFS_STRIDE);
    localparam logic [AW-1:0] A_FALL = AW'(int'(OFS_FALL0) + p * OFS_STRIDE);
    logic [DW-1:0] rise_q;
    logic [DW-1:0] fall_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        rise_q <= '0;
        fall_q <= '0;
      end else if (wr_en) begin
        if (addr == A_RISE) rise_q <= wdata;
        if (addr == A_FALL) fall_q <= wdata;
      end
    end

    assign rise_en[p*DW +: DW] = rise_q;
    assign fall_en[p*DW +: DW] = fall_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && addr == A_CTRL) begin
      ctrl_q <= ctrl_t'(wdata[CW-1:0]);
    end
  end

  assign clr_edge = wr_en && (addr == A_CLEAR) && wdata[CLR_EDGE_BIT];
  assign clr_ovf  = wr_en && (addr == A_CLEAR) && wdata[CLR_OVF_BIT];

endmodule

// File: rtl/chg_status.sv
module chg_status
  import chg_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hit,
  input  logic  clr_edge,
  input  logic  clr_ovf,
  input  ctrl_t ctrl_q,
  output logic  edge_q,
  output logic  ovf_q,
  output logic  irq_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // a new qualifying change beats a simultaneous clear
      edge_q <= hit | (edge_q & ~clr_edge);
      ovf_q  <= (hit & edge_q) | (ovf_q & ~clr_ovf);
      irq_q  <= ctrl_q.master &
                ((edge_q & ctrl_q.edge_ie) | (ovf_q & ctrl_q.ovf_ie));
    end
  end

endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
  import chg_irq_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int DW     = 8,
  parameter int AW     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic [NPORTS*DW-1:0] port_in,
  output logic                 irq
);

  localparam int IW = NPORTS * DW;
  localparam int CW = $bits(ctrl_t);
  localparam logic [AW-1:0] A_STATUS = AW'(OFS_STATUS);
  localparam logic [AW-1:0] A_CTRL   = AW'(OFS_CTRL);

  logic [IW-1:0] rise;
  logic [IW-1:0] fall;
  logic [IW-1:0] rise_en;
  logic [IW-1:0] fall_en;
  ctrl_t         ctrl_q;
  logic          clr_edge;
  logic          clr_ovf;
  logic          hit;
  logic          edge_q;
  logic          ovf_q;
  logic          irq_q;
  logic [DW-1:0] rd_next;

  chg_sync #(.W(IW)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (port_in),
    .rise (rise),
    .fall (fall)
  );

  chg_regs #(.NPORTS(NPORTS), .DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .ctrl_q   (ctrl_q),
    .clr_edge (clr_edge),
    .clr_ovf  (clr_ovf)
  );

  assign hit = (ctrl_q.rise_gate & |(rise & rise_en)) |
               (ctrl_q.fall_gate & |(fall & fall_en));

  chg_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .clr_edge (clr_edge),
    .clr_ovf  (clr_ovf),
    .ctrl_q   (ctrl_q),
    .edge_q   (edge_q),
    .ovf_q    (ovf_q),
    .irq_q    (irq_q)
  );

  always_comb begin
    rd_next = '0;
    if (addr == A_STATUS) begin
      rd_next[0] = edge_q;
      rd_next[1] = ovf_q;
      rd_next[2] = irq_q;
    end else if (addr == A_CTRL) begin
      rd_next[CW-1:0] = ctrl_q;
    end
    for (int p = 0; p < NPORTS; p++) begin
      if (addr == AW'(int'(OFS_RISE0) + p * OFS_STRIDE)) rd_next = rise_en[p*DW +: DW];
      if (addr == AW'(int'(OFS_FALL0) + p * OFS_STRIDE)) rd_next = fall_en[p*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assign irq = irq_q;

endmodule

// File: rtl/chg_irq_chk.sv
module chg_irq_chk
  import chg_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          irq,
  input ctrl_t         ctrl_q,
  input logic          edge_q,
  input logic          ovf_q,
  input logic          hit
);

  logic wr_clear_edge;
  logic wr_ctrl_zero;
  assign wr_clear_edge = wr_en && addr == AW'(OFS_CLEAR) && wdata[CLR_EDGE_BIT];
  assign wr_ctrl_zero  = wr_en && addr == AW'(OFS_CTRL) && wdata == '0;

  assert_flag_needs_hit_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(edge_q) |-> $past(hit));

  assert_ovf_needs_edge_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(edge_q));

  assert_clear_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_clear_edge && !hit) |=> !edge_q);

  assert_clear_race_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_clear_edge && hit) |=> edge_q);

  assert_irq_needs_master_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctrl_q.master));

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(edge_q || ovf_q));

  assert_ctrl_zero_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl_zero |-> ##2 !irq);

endmodule

bind chg_irq_ctrl chg_irq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .irq    (irq),
  .ctrl_q (ctrl_q),
  .edge_q (edge_q),
  .ovf_q  (ovf_q),
  .hit    (hit)
);

// File: tb/chg_irq_ctrl_test.sv
module chg_irq_ctrl_test;

  localparam int NPORTS = 4;
  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam logic [7:0] A_CLR  = 8'h01;
  localparam logic [7:0] A_STAT = 8'h02;
  localparam logic [7:0] A_CTRL = 8'h03;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 wr_en = 1'b0;
  logic [AW-1:0]        addr = '0;
  logic [DW-1:0]        wdata = '0;
  logic [DW-1:0]        rdata;
  logic [NPORTS*DW-1:0] port_in = '0;
  logic                 irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  chg_irq_ctrl #(.NPORTS(NPORTS), .DW(DW), .AW(AW)) uut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .port_in (port_in),
    .irq     (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) tick();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    tick();
    v = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_STAT, v); chk("R1 status", v, 8'h00);
    rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
    rd(8'h42, v);  chk("R1 rise0", v, 8'h00);
    rd(8'h73, v);  chk("R1 fall3", v, 8'h00);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    wr(8'h42, 8'h5A);
    wr(8'h73, 8'hC3);
    wr(A_CTRL, 8'h1F);
    rd(8'h42, v);  chk("R2 rise port0", v, 8'h5A);
    rd(8'h73, v);  chk("R2 fall port3", v, 8'hC3);
    rd(8'h52, v);  chk("R2 rise port1", v, 8'h00);
    rd(A_CTRL, v); chk("R11 ctrl", v, 8'h1F);
    wr(A_CTRL, 8'h00);
    wr(8'h42, 8'h00);
    wr(8'h73, 8'h00);
  endtask

  task automatic t_rise_latency();
    logic [7:0] v;
    wr(8'h52, 8'h01);
    wr(A_CTRL, 8'h0D);
    addr = A_STAT;
    port_in[8] = 1'b1;
    tick(); tick(); tick();
    chk("R3 flag not yet visible at E3", rdata[0], 1'b0);
    tick();
    chk("R3 status at E4", rdata, 8'h01);
    chk("R9 irq at E4", irq, 1'b1);
    tick();
    chk("R9 status irq bit at E5", rdata, 8'h05);
    wr(A_CLR, 8'h0C);
    settle();
    rd(A_STAT, v); chk("R7 both cleared", v, 8'h00);
    chk("R7 irq low", irq, 1'b0);
  endtask

  task automatic t_fall_and_masks();
    logic [7:0] v;
    wr(8'h53, 8'h01);
    port_in[8] = 1'b0;
    settle();
    rd(A_STAT, v); chk("R5 fall gate clear", v, 8'h00);
    wr(A_CTRL, 8'h15);
    port_in[8] = 1'b1;
    settle();
    rd(A_STAT, v); chk("R5 rise gate clear", v, 8'h00);
    port_in[9] = 1'b1; settle();
    port_in[9] = 1'b0; settle();
    rd(A_STAT, v); chk("R5 unarmed bit", v, 8'h00);
    port_in[8] = 1'b0;
    settle();
    rd(A_STAT, v); chk("R4 falling sets flag", v, 8'h05);
    chk("R4 irq", irq, 1'b1);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    port_in[8] = 1'b1; settle();
    port_in[8] = 1'b0; settle();
    rd(A_STAT, v); chk("R6 overflow set", v, 8'h07);
    wr(A_CLR, 8'hF3); settle();
    rd(A_STAT, v); chk("R7 other clear bits ignored", v, 8'h07);
    wr(A_CLR, 8'h08); settle();
    rd(A_STAT, v); chk("R7 edge only cleared", v, 8'h02);
    chk("R9 ovf without ovf enable", irq, 1'b0);
    wr(A_CTRL, 8'h17); settle();
    rd(A_STAT, v); chk("R9 ovf source", v, 8'h06);
    chk("R9 irq from ovf", irq, 1'b1);
    wr(A_CLR, 8'h04); settle();
    rd(A_STAT, v); chk("R7 ovf cleared", v, 8'h00);
    chk("R7 irq low after ovf clear", irq, 1'b0);
  endtask

  task automatic t_race();
    logic [7:0] v;
    port_in[8] = 1'b1; settle();
    port_in[8] = 1'b0; settle();
    rd(A_STAT, v); chk("R8 setup flag", v, 8'h05);
    port_in[8] = 1'b1; settle();
    port_in[8] = 1'b0;
    tick(); tick();
    wr(A_CLR, 8'h08);
    settle();
    rd(A_STAT, v); chk("R8 edge survives clear", v[0], 1'b1);
  endtask

  task automatic t_ctrl_off();
    logic [7:0] v;
    wr(A_CTRL, 8'h00);
    tick();
    chk("R10 irq drops", irq, 1'b0);
    wr(A_CLR, 8'h0C);
    port_in[8] = 1'b1; settle();
    port_in[8] = 1'b0; settle();
    rd(A_STAT, v); chk("R10 no flag when off", v, 8'h00);
    chk("R10 irq stays low", irq, 1'b0);
  endtask

  task automatic t_port3();
    logic [7:0] v;
    wr(8'h72, 8'h80);
    wr(A_CTRL, 8'h0D);
    port_in[31] = 1'b1;
    port_in[24] = 1'b1;
    settle();
    rd(A_STAT, v); chk("R3 port3 bit7", v, 8'h05);
    chk("R3 port3 irq", irq, 1'b1);
    wr(A_CLR, 8'h0C); settle();
    rd(A_STAT, v); chk("R7 port3 cleared", v, 8'h00);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_readback();
    t_rise_latency();
    t_fall_and_masks();
    t_overflow();
    t_race();
    t_ctrl_off();
    t_port3();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule